// File: doc/BRIEF.md
# Aliased Dual Accumulator Register

This block holds two 8-bit working registers, A and B, that can also be addressed together as one 16-bit register, D. D has no storage of its own: it is always A placed above B. Any operation on D therefore rewrites both byte registers, and any byte operation shows up at once in the matching half of D.

A 4-bit operation code selects one action per clock. The actions are: a byte load into A or into B, a word load that fills both halves from one 16-bit input, adding B into A, adding the word input to D, subtracting it from D, shifting D one place left or right across the byte boundary, and copying an 8-bit condition-code input into A. Arithmetic and shifts also update a carry flag and a zero flag, each sized to the width of the operation. The block sits inside a processor datapath. Decode and memory access are done elsewhere.

Reset is asynchronous and active low. Its release is synchronised inside the block, so the registers leave reset a fixed number of clocks (parameter SYNC_STAGES, default 2) after the reset input goes high.

Top module: `dual_acc`

## Requirements
- R1: While reset is active, A, B, carry and zero are all 0. The registers leave reset SYNC_STAGES clock edges after rst_n rises.
- R2: acc_d_o always equals {acc_a_o, acc_b_o}. A word operation rewrites both byte registers in the same clock.
- R3: Opcode 0x1 loads mem_i[7:0] into A and leaves B unchanged. Opcode 0x2 loads mem_i[7:0] into B and leaves A unchanged.
- R4: Opcode 0x3 loads mem_i[15:8] into A and mem_i[7:0] into B.
- R5: Opcode 0x4 writes (A + B) mod 256 into A and leaves B unchanged. Carry is the carry out of bit 7. Zero is 1 when the 8-bit result is 0.
- R6: Opcode 0x5 writes (D + mem_i) mod 65536 into D. Carry is the carry out of bit 15. Zero is 1 when the 16-bit result is 0.
- R7: Opcode 0x6 writes (D - mem_i) mod 65536 into D. Carry is 1 when mem_i is greater than D (a borrow). Zero is 1 when the result is 0.
- R8: Opcode 0x7 shifts D left by one place and brings in 0 at bit 0. Bit 7 of B moves into bit 0 of A. Carry takes the old D bit 15. Zero reflects the 16-bit result.
- R9: Opcode 0x8 shifts D right by one place and brings in 0 at bit 15 (the default, logical variant). Bit 0 of A moves into bit 7 of B. Carry takes the old D bit 0. Zero reflects the 16-bit result.
- R10: Opcode 0x9 copies ccr_i into A and leaves B unchanged. No opcode copies ccr_i into B.
- R11: Opcode 0x0 and the unassigned opcodes 0xA to 0xF leave A, B, carry and zero unchanged. Loads (0x1, 0x2, 0x3) and the transfer (0x9) leave carry and zero unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code for this clock |
| mem_i | input | 16 | Word operand from memory |
| ccr_i | input | 8 | Condition-code value for the transfer into A |
| acc_a_o | output | 8 | Register A |
| acc_b_o | output | 8 | Register B |
| acc_d_o | output | 16 | A and B seen as one word, A high |
| carry_o | output | 1 | Carry or borrow flag |
| zero_o | output | 1 | Zero flag |

## Verification
The bound checker tests every opcode on every clock against the register values from the clock before. It covers the byte and word loads, the 8-bit and 16-bit sums, the borrow rule of the subtraction, the carry and the bits that cross the byte boundary on both shifts, and the holding of registers and flags on no-op and unassigned codes.

Some behaviour is outside those per-clock checks and only the bench scenarios show it. These are the reset value and the delay before registers leave reset, the exact 16-bit difference, and the zero flag on word results. They also include the carry and zero that a whole chain of mixed operations leaves behind, which the bench compares with its own behavioural model after every clock.

// File: rtl/dual_acc_pkg.sv
package dual_acc_pkg;
  localparam int OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_NOP  = 4'h0,
    OP_LDA  = 4'h1,
    OP_LDB  = 4'h2,
    OP_LDD  = 4'h3,
    OP_ABA  = 4'h4,
    OP_ADDD = 4'h5,
    OP_SUBD = 4'h6,
    OP_SHLD = 4'h7,
    OP_SHRD = 4'h8,
    OP_TCA  = 4'h9
  } acc_op_e;
endpackage

// File: rtl/dual_acc_rst_sync.sv
module dual_acc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/dual_acc_alu.sv
module dual_acc_alu
  import dual_acc_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter bit SHR_ARITH = 1'b0
) (
  input  logic [OPC_W-1:0]    op_i,
  input  logic [BYTE_W-1:0]   a_i,
  input  logic [BYTE_W-1:0]   b_i,
  input  logic [2*BYTE_W-1:0] mem_i,
  input  logic [BYTE_W-1:0]   ccr_i,
  output logic [BYTE_W-1:0]   a_nxt,
  output logic [BYTE_W-1:0]   b_nxt,
  output logic                a_we,
  output logic                b_we,
  output logic                flag_we,
  output logic                c_nxt,
  output logic                z_nxt
);
  localparam int WORD_W = 2 * BYTE_W;

  logic [WORD_W-1:0] d_cur;
  logic [BYTE_W:0]   sum_byte;
  logic [WORD_W:0]   sum_word;
  logic [WORD_W:0]   dif_word;
  logic [WORD_W-1:0] res_word;
  logic              shr_fill;

  assign d_cur    = {a_i, b_i};
  assign sum_byte = {1'b0, a_i} + {1'b0, b_i};
  assign sum_word = {1'b0, d_cur} + {1'b0, mem_i};
  assign dif_word = {1'b0, d_cur} - {1'b0, mem_i};

  generate
    if (SHR_ARITH) begin : g_shr_arith
      assign shr_fill = d_cur[WORD_W-1];
    end else begin : g_shr_logic
      assign shr_fill = 1'b0;
    end
  endgenerate

  always_comb begin
    a_nxt    = a_i;
    b_nxt    = b_i;
    a_we     = 1'b0;
    b_we     = 1'b0;
    flag_we  = 1'b0;
    c_nxt    = 1'b0;
    z_nxt    = 1'b0;
    res_word = d_cur;
    case (op_i)
      OP_LDA: begin
        a_nxt = mem_i[BYTE_W-1:0];
        a_we  = 1'b1;
      end
      OP_LDB: begin
        b_nxt = mem_i[BYTE_W-1:0];
        b_we  = 1'b1;
      end
      OP_LDD: begin
        a_nxt = mem_i[WORD_W-1:BYTE_W];
        b_nxt = mem_i[BYTE_W-1:0];
        a_we  = 1'b1;
        b_we  = 1'b1;
      end
      OP_ABA: begin
        a_nxt   = sum_byte[BYTE_W-1:0];
        a_we    = 1'b1;
        flag_we = 1'b1;
        c_nxt   = sum_byte[BYTE_W];
        z_nxt   = (sum_byte[BYTE_W-1:0] == '0);
      end
      OP_ADDD, OP_SUBD, OP_SHLD, OP_SHRD: begin
        case (op_i)
          OP_ADDD: begin
            res_word = sum_word[WORD_W-1:0];
            c_nxt    = sum_word[WORD_W];
          end
          OP_SUBD: begin
            res_word = dif_word[WORD_W-1:0];
            c_nxt    = dif_word[WORD_W];
          end
          OP_SHLD: begin
            res_word = {d_cur[WORD_W-2:0], 1'b0};
            c_nxt    = d_cur[WORD_W-1];
          end
          default: begin
            res_word = {shr_fill, d_cur[WORD_W-1:1]};
            c_nxt    = d_cur[0];
          end
        endcase
        a_nxt   = res_word[WORD_W-1:BYTE_W];
        b_nxt   = res_word[BYTE_W-1:0];
        a_we    = 1'b1;
        b_we    = 1'b1;
        flag_we = 1'b1;
        z_nxt   = (res_word == '0);
      end
      OP_TCA: begin
        a_nxt = ccr_i;
        a_we  = 1'b1;
      end
      default: begin
      end
    endcase
  end
endmodule

// File: rtl/dual_acc_regs.sv
module dual_acc_regs #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_we,
  input  logic              b_we,
  input  logic              flag_we,
  input  logic [BYTE_W-1:0] a_nxt,
  input  logic [BYTE_W-1:0] b_nxt,
  input  logic              c_nxt,
  input  logic              z_nxt,
  output logic [BYTE_W-1:0] a_q,
  output logic [BYTE_W-1:0] b_q,
  output logic              c_q,
  output logic              z_q
);
  logic [BYTE_W-1:0] a_d;
  logic [BYTE_W-1:0] b_d;
  logic              c_d;
  logic              z_d;

  always_comb begin
    a_d = a_we    ? a_nxt : a_q;
    b_d = b_we    ? b_nxt : b_q;
    c_d = flag_we ? c_nxt : c_q;
    z_d = flag_we ? z_nxt : z_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
      c_q <= 1'b0;
      z_q <= 1'b0;
    end else begin
      a_q <= a_d;
      b_q <= b_d;
      c_q <= c_d;
      z_q <= z_d;
    end
  end
endmodule

// File: rtl/dual_acc.sv
module dual_acc
  import dual_acc_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit SHR_ARITH   = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [OPC_W-1:0]    op_i,
  input  logic [2*BYTE_W-1:0] mem_i,
  input  logic [BYTE_W-1:0]   ccr_i,
  output logic [BYTE_W-1:0]   acc_a_o,
  output logic [BYTE_W-1:0]   acc_b_o,
  output logic [2*BYTE_W-1:0] acc_d_o,
  output logic                carry_o,
  output logic                zero_o
);
  logic              rst_sync_n;
  logic [BYTE_W-1:0] a_nxt;
  logic [BYTE_W-1:0] b_nxt;
  logic              a_we;
  logic              b_we;
  logic              flag_we;
  logic              c_nxt;
  logic              z_nxt;

  dual_acc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dual_acc_alu #(.BYTE_W(BYTE_W), .SHR_ARITH(SHR_ARITH)) u_alu (
    .op_i    (op_i),
    .a_i     (acc_a_o),
    .b_i     (acc_b_o),
    .mem_i   (mem_i),
    .ccr_i   (ccr_i),
    .a_nxt   (a_nxt),
    .b_nxt   (b_nxt),
    .a_we    (a_we),
    .b_we    (b_we),
    .flag_we (flag_we),
    .c_nxt   (c_nxt),
    .z_nxt   (z_nxt)
  );

  dual_acc_regs #(.BYTE_W(BYTE_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .a_we    (a_we),
    .b_we    (b_we),
    .flag_we (flag_we),
    .a_nxt   (a_nxt),
    .b_nxt   (b_nxt),
    .c_nxt   (c_nxt),
    .z_nxt   (z_nxt),
    .a_q     (acc_a_o),
    .b_q     (acc_b_o),
    .c_q     (carry_o),
    .z_q     (zero_o)
  );

  assign acc_d_o = {acc_a_o, acc_b_o};
endmodule

// File: rtl/dual_acc_checker.sv
module dual_acc_checker
  import dual_acc_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rst_sync_n,
  input logic [OPC_W-1:0]    op_i,
  input logic [2*BYTE_W-1:0] mem_i,
  input logic [BYTE_W-1:0]   ccr_i,
  input logic [BYTE_W-1:0]   acc_a_o,
  input logic [BYTE_W-1:0]   acc_b_o,
  input logic [2*BYTE_W-1:0] acc_d_o,
  input logic                carry_o,
  input logic                zero_o
);
  localparam int WORD_W = 2 * BYTE_W;

  logic idle_code;
  assign idle_code = (op_i == OP_NOP) || (op_i > OP_TCA);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    idle_code |=> $stable(acc_a_o) && $stable(acc_b_o) && $stable(carry_o) && $stable(zero_o));

  p_load_flags_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_i == OP_LDA || op_i == OP_LDB || op_i == OP_LDD || op_i == OP_TCA)
      |=> $stable(carry_o) && $stable(zero_o));

  p_lda_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_i == OP_LDA) |=> (acc_a_o == $past(mem_i[BYTE_W-1:0])) && $stable(acc_b_o));

  p_ldb_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_i == OP_LDB) |=> (acc_b_o == $past(mem_i[BYTE_W-1:0])) && $stable(acc_a_o));

  p_ldd_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_i == OP_LDD) |=> (acc_d_o == $past(mem_i)) && (acc_a_o == $past(mem_i[WORD_W-1:BYTE_W])));

  p_aba_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_i == OP_ABA) |=> (acc_a_o == BYTE_W'($past(acc_a_o) + $past(acc_b_o))) && $stable(acc_b_o)
                         && (zero_o == (acc_a_o == '0)));

  p_addd_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_i == OP_ADDD) |=> (acc_d_o == WORD_W'($past(acc_d_o) + $past(mem_i))));

  p_subd_borrow_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_i == OP_SUBD) |=> (carry_o == ($past(mem_i) > $past(acc_d_o))));

  p_shl_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_i == OP_SHLD) |=> (carry_o == $past(acc_d_o[WORD_W-1]))
                          && (acc_d_o[WORD_W-1:1] == $past(acc_d_o[WORD_W-2:0]))
                          && (acc_d_o[0] == 1'b0));

  p_shr_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_i == OP_SHRD) |=> (carry_o == $past(acc_d_o[0]))
                          && (acc_d_o[WORD_W-2:0] == $past(acc_d_o[WORD_W-1:1])));

  p_tca_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_i == OP_TCA) |=> (acc_a_o == $past(ccr_i)) && $stable(acc_b_o));
endmodule

bind dual_acc dual_acc_checker #(.BYTE_W(BYTE_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .op_i       (op_i),
  .mem_i      (mem_i),
  .ccr_i      (ccr_i),
  .acc_a_o    (acc_a_o),
  .acc_b_o    (acc_b_o),
  .acc_d_o    (acc_d_o),
  .carry_o    (carry_o),
  .zero_o     (zero_o)
);

// File: tb/dual_acc_test.sv
`timescale 1ns/1ps
module dual_acc_test;
  logic        clk;
  logic        rst_n;
  logic [3:0]  op_i;
  logic [15:0] mem_i;
  logic [7:0]  ccr_i;
  logic [7:0]  acc_a_o;
  logic [7:0]  acc_b_o;
  logic [15:0] acc_d_o;
  logic        carry_o;
  logic        zero_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // reference state
  int ma = 0, mb = 0, mc = 0, mz = 0;

  dual_acc uut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .mem_i(mem_i), .ccr_i(ccr_i),
    .acc_a_o(acc_a_o), .acc_b_o(acc_b_o), .acc_d_o(acc_d_o),
    .carry_o(carry_o), .zero_o(zero_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int op);
    case (op)
      1, 2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      6: return "R7";
      7: return "R8";
      8: return "R9";
      9: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic compare_all(input string tag);
    check(tag, "A", int'(acc_a_o), ma);
    check(tag, "B", int'(acc_b_o), mb);
    check("R2", "D", int'(acc_d_o), ma * 256 + mb);
    check(tag, "carry", int'(carry_o), mc);
    check(tag, "zero", int'(zero_o), mz);
  endtask

  // drive one operation at a falling edge, update the model, compare at the next falling edge
  task automatic step(input int op, input int mem, input int ccr);
    int dv;
    int s;
    op_i  = 4'(op);
    mem_i = 16'(mem);
    ccr_i = 8'(ccr);
    dv = ma * 256 + mb;
    case (op)
      1: ma = mem & 255;
      2: mb = mem & 255;
      3: begin ma = (mem >> 8) & 255; mb = mem & 255; end
      4: begin s = ma + mb; mc = (s > 255) ? 1 : 0; ma = s & 255; mz = (ma == 0) ? 1 : 0; end
      5, 6, 7, 8: begin
        case (op)
          5: begin s = dv + mem; mc = (s > 65535) ? 1 : 0; end
          6: begin s = dv - mem; mc = (mem > dv) ? 1 : 0; end
          7: begin s = dv * 2;   mc = (dv >> 15) & 1; end
          default: begin s = dv / 2; mc = dv & 1; end
        endcase
        s  = s & 65535;
        mz = (s == 0) ? 1 : 0;
        ma = s >> 8;
        mb = s & 255;
      end
      9: ma = ccr & 255;
      default: ;
    endcase
    @(negedge clk);
    compare_all(tag_of(op));
  endtask

  initial begin
    #100000;
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    op_i  = 4'h3;
    mem_i = 16'hBEEF;
    ccr_i = 8'h5A;
    repeat (3) @(negedge clk);
    // R1: reset holds everything at zero even with a load presented
    compare_all("R1");
    rst_n = 1'b1;
    // R1: still in reset for the first edge after release (two-stage sync)
    @(negedge clk);
    compare_all("R1");
    @(negedge clk);
    // second edge released the synchroniser output; the register has not loaded yet
    compare_all("R1");
    // the next edge is the first one that loads
    ma = 8'hBE; mb = 8'hEF;
    @(negedge clk);
    compare_all("R4");

    // directed corner cases
    step(0, 16'hFFFF, 8'hFF);          // R11 hold
    step(3, 16'h12FF, 0);              // R4 word load
    step(4, 0, 0);                     // R5: 0x12+0xFF carry, A=0x11
    step(1, 16'hAA00, 0);              // R3 A=0
    step(2, 16'h5500, 0);              // R3 B=0
    step(4, 0, 0);                     // R5: zero result, no carry
    step(3, 16'hFFFF, 0);
    step(5, 16'h0001, 0);              // R6 wrap to zero, carry and zero
    step(6, 16'h0001, 0);              // R7 borrow from zero -> 0xFFFF
    step(6, 16'hFFFF, 0);              // R7 equal -> zero, no borrow
    step(3, 16'h0080, 0);
    step(7, 0, 0);                     // R8 B bit7 crosses into A bit0
    step(8, 0, 0);                     // R9 A bit0 crosses into B bit7
    step(3, 16'h8001, 0);
    step(7, 0, 0);                     // R8 carry from bit 15
    step(3, 16'h8001, 0);
    step(8, 0, 0);                     // R9 carry from bit 0, zero fill on top
    step(9, 0, 8'hC3);                 // R10 transfer into A only
    step(12, 16'h1234, 8'h77);         // R11 unassigned code holds
    step(15, 16'h4321, 8'h11);         // R11 unassigned code holds

    // mixed sequence
    for (int i = 0; i < 400; i++) begin
      step(int'($urandom_range(0, 15)), int'($urandom_range(0, 65535)), int'($urandom_range(0, 255)));
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule